// File: doc/BRIEF.md
# Block-Transfer Read/Write Arbiter

This block chooses between one read requester and one write requester. Each requester wants to move a whole block of data to or from a memory. Each side holds a level request together with a 22-bit start pointer. The pointer counts 16-byte units.

When the block is idle and a request is present, it grants one side. It answers that side with a single-cycle acknowledge and captures the side's pointer and the transfer direction. One cycle later it hands the pointer and direction to the memory-side controller with a start strobe. It then stays busy and grants nothing more until the memory side reports completion for the direction it is serving.

When both sides are waiting, priority alternates between the two directions. After reset the write side is preferred.

Top module: `blk_xfer_arb`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, rd_ack_o, wr_ack_o and start_o are 0.
- R2: When the block is idle and only one request is high at a rising edge, that side's acknowledge is 1 for exactly the following cycle, busy_o rises with it, and the other acknowledge stays 0.
- R3: After reset, if both requests are high at the same edge, the write side is granted.
- R4: With both requests pending, the side not granted most recently wins: after a write grant the read side wins, and after a read grant the write side wins.
- R5: While busy_o is 1, no acknowledge is issued, whatever the request inputs do.
- R6: busy_o clears only at an edge where the done input of the active direction (rd_done_i for a read, wr_done_i for a write) is 1. The other done input is ignored, and a done input has no effect while idle.
- R7: A request held across a release is granted at the edge after the one that cleared busy_o, not earlier.
- R8: start_o is 1 for exactly the cycle after an acknowledge. start_ptr_o carries the granted side's pointer and start_is_wr_o is 1 for a write and 0 for a read. start_ptr_o and start_is_wr_o stay stable while busy_o is 1.
- R9: rd_ack_o and wr_ack_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Read block request level |
| rd_ptr_i | input | 22 | Read start pointer, 16-byte units |
| wr_req_i | input | 1 | Write block request level |
| wr_ptr_i | input | 22 | Write start pointer, 16-byte units |
| rd_done_i | input | 1 | Memory side finished the read block |
| wr_done_i | input | 1 | Memory side finished the write block |
| rd_ack_o | output | 1 | One-cycle read grant |
| wr_ack_o | output | 1 | One-cycle write grant |
| busy_o | output | 1 | A granted block transfer is outstanding |
| start_o | output | 1 | Start strobe to the memory side |
| start_ptr_o | output | 22 | Captured start pointer |
| start_is_wr_o | output | 1 | Captured direction, 1 = write |

## Verification
An acknowledge and busy_o appear one edge after the request is sampled. The start strobe, pointer and direction follow one edge after the acknowledge. busy_o falls one edge after the matching done is sampled, and a held request is granted one edge after that. The bench drives inputs on falling edges and reads outputs on the next falling edge, so every check falls exactly one register stage after its stimulus. Checks are made at each intermediate cycle to confirm that nothing changes early or late.

// File: rtl/blk_arb_pkg.sv
package blk_arb_pkg;
  localparam int unsigned PTR_W = 22;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} xfer_dir_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick (
  input  logic en_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic prio_wr_i,
  output logic pick_rd_o,
  output logic pick_wr_o
);
  always_comb begin
    pick_rd_o = 1'b0;
    pick_wr_o = 1'b0;
    if (en_i) begin
      if (rd_req_i && wr_req_i) begin
        pick_wr_o = prio_wr_i;
        pick_rd_o = !prio_wr_i;
      end else begin
        pick_rd_o = rd_req_i;
        pick_wr_o = wr_req_i;
      end
    end
  end
endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
  import blk_arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pick_rd_i,
  input  logic      pick_wr_i,
  input  logic      rd_done_i,
  input  logic      wr_done_i,
  output logic      idle_o,
  output logic      prio_wr_o,
  output logic      rd_ack_o,
  output logic      wr_ack_o,
  output logic      busy_o
);
  logic      busy_q, rd_ack_q, wr_ack_q, prio_wr_q;
  xfer_dir_e dir_q;
  logic      done_hit;

  assign done_hit = (dir_q == DIR_WR) ? wr_done_i : rd_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_ack_q  <= 1'b0;
      wr_ack_q  <= 1'b0;
      prio_wr_q <= 1'b1;
      dir_q     <= DIR_WR;
    end else begin
      rd_ack_q <= 1'b0;
      wr_ack_q <= 1'b0;
      if (!busy_q) begin
        if (pick_wr_i) begin
          busy_q    <= 1'b1;
          wr_ack_q  <= 1'b1;
          dir_q     <= DIR_WR;
          prio_wr_q <= 1'b0;
        end else if (pick_rd_i) begin
          busy_q    <= 1'b1;
          rd_ack_q  <= 1'b1;
          dir_q     <= DIR_RD;
          prio_wr_q <= 1'b1;
        end
      end else if (done_hit) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign idle_o    = !busy_q;
  assign prio_wr_o = prio_wr_q;
  assign rd_ack_o  = rd_ack_q;
  assign wr_ack_o  = wr_ack_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/arb_launch_reg.sv
module arb_launch_reg
  import blk_arb_pkg::*;
#(
  parameter int unsigned W = PTR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_rd_i,
  input  logic         fire_wr_i,
  input  logic [W-1:0] rd_ptr_i,
  input  logic [W-1:0] wr_ptr_i,
  input  logic         ack_any_i,
  output logic         start_o,
  output logic [W-1:0] ptr_o,
  output logic         is_wr_o
);
  logic [W-1:0] ptr_q;
  logic         is_wr_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      is_wr_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= ack_any_i;
      if (fire_wr_i) begin
        ptr_q   <= wr_ptr_i;
        is_wr_q <= 1'b1;
      end else if (fire_rd_i) begin
        ptr_q   <= rd_ptr_i;
        is_wr_q <= 1'b0;
      end
    end
  end

  assign start_o = start_q;
  assign ptr_o   = ptr_q;
  assign is_wr_o = is_wr_q;
endmodule

// File: rtl/blk_xfer_arb.sv
module blk_xfer_arb
  import blk_arb_pkg::*;
#(
  parameter int unsigned PW = PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [PW-1:0] rd_ptr_i,
  input  logic          wr_req_i,
  input  logic [PW-1:0] wr_ptr_i,
  input  logic          rd_done_i,
  input  logic          wr_done_i,
  output logic          rd_ack_o,
  output logic          wr_ack_o,
  output logic          busy_o,
  output logic          start_o,
  output logic [PW-1:0] start_ptr_o,
  output logic          start_is_wr_o
);
  logic idle, prio_wr, pick_rd, pick_wr;

  arb_rr_pick u_pick (
    .en_i      (idle),
    .rd_req_i  (rd_req_i),
    .wr_req_i  (wr_req_i),
    .prio_wr_i (prio_wr),
    .pick_rd_o (pick_rd),
    .pick_wr_o (pick_wr)
  );

  arb_grant_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pick_rd_i (pick_rd),
    .pick_wr_i (pick_wr),
    .rd_done_i (rd_done_i),
    .wr_done_i (wr_done_i),
    .idle_o    (idle),
    .prio_wr_o (prio_wr),
    .rd_ack_o  (rd_ack_o),
    .wr_ack_o  (wr_ack_o),
    .busy_o    (busy_o)
  );

  arb_launch_reg #(.W(PW)) u_launch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_rd_i (pick_rd),
    .fire_wr_i (pick_wr),
    .rd_ptr_i  (rd_ptr_i),
    .wr_ptr_i  (wr_ptr_i),
    .ack_any_i (rd_ack_o | wr_ack_o),
    .start_o   (start_o),
    .ptr_o     (start_ptr_o),
    .is_wr_o   (start_is_wr_o)
  );
endmodule

// File: rtl/blk_xfer_arb_chk.sv
module blk_xfer_arb_chk #(
  parameter int unsigned PW = 22
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_done_i,
  input logic          wr_done_i,
  input logic          rd_ack_o,
  input logic          wr_ack_o,
  input logic          busy_o,
  input logic          start_o,
  input logic [PW-1:0] start_ptr_o,
  input logic          start_is_wr_o
);
  a_r9_ack_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_ack_o, wr_ack_o}));

  a_r2_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o || wr_ack_o) |=> !(rd_ack_o || wr_ack_o));

  a_r5_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o || wr_ack_o) |-> !$past(busy_o));

  a_r2_busy_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o || wr_ack_o) |-> busy_o);

  a_r6_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rd_done_i && !wr_done_i) |=> busy_o);

  a_r8_start_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack_o || wr_ack_o) |=> start_o);

  a_r8_start_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (start_is_wr_o == $past(wr_ack_o)));

  a_r8_ptr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(start_ptr_o) && $stable(start_is_wr_o)));
endmodule

bind blk_xfer_arb blk_xfer_arb_chk #(.PW(PW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_done_i     (rd_done_i),
  .wr_done_i     (wr_done_i),
  .rd_ack_o      (rd_ack_o),
  .wr_ack_o      (wr_ack_o),
  .busy_o        (busy_o),
  .start_o       (start_o),
  .start_ptr_o   (start_ptr_o),
  .start_is_wr_o (start_is_wr_o)
);

// File: tb/blk_xfer_arb_bench.sv
`timescale 1ns/1ps
module blk_xfer_arb_bench;
  localparam int PW = 22;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, rd_done = 1'b0, wr_done = 1'b0;
  logic [PW-1:0] rd_ptr = '0, wr_ptr = '0;
  logic rd_ack, wr_ack, busy, start, start_is_wr;
  logic [PW-1:0] start_ptr;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  blk_xfer_arb u_blk_xfer_arb (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_req_i(rd_req), .rd_ptr_i(rd_ptr),
    .wr_req_i(wr_req), .wr_ptr_i(wr_ptr),
    .rd_done_i(rd_done), .wr_done_i(wr_done),
    .rd_ack_o(rd_ack), .wr_ack_o(wr_ack), .busy_o(busy),
    .start_o(start), .start_ptr_o(start_ptr), .start_is_wr_o(start_is_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rd_req = 0; wr_req = 0; rd_done = 0; wr_done = 0;
    rst_ni = 0;
    step(); step();
    rst_ni = 1;
    step();
  endtask

  task automatic release_side(input bit is_wr);
    if (is_wr) wr_done = 1; else rd_done = 1;
    step();
    wr_done = 0; rd_done = 0;
    chk("R6 busy cleared by matching done", busy, 0);
  endtask

  task automatic t_r1_reset();
    rst_ni = 0;
    step();
    chk("R1 busy in reset", busy, 0);
    chk("R1 acks in reset", {rd_ack, wr_ack}, 0);
    do_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 start after reset", start, 0);
  endtask

  task automatic t_r2_single(input bit is_wr, input logic [PW-1:0] p);
    if (is_wr) begin wr_req = 1; wr_ptr = p; end
    else begin rd_req = 1; rd_ptr = p; end
    step();
    wr_req = 0; rd_req = 0;
    chk("R2 granted ack", is_wr ? wr_ack : rd_ack, 1);
    chk("R2 other ack", is_wr ? rd_ack : wr_ack, 0);
    chk("R2 busy", busy, 1);
    step();
    chk("R2 ack one cycle", {rd_ack, wr_ack}, 0);
    chk("R8 start", start, 1);
    chk("R8 ptr", start_ptr, p);
    chk("R8 dir", start_is_wr, is_wr);
    step();
    chk("R8 start one cycle", start, 0);
    release_side(is_wr);
  endtask

  task automatic t_r3_r4_alternate();
    do_reset();
    rd_ptr = 22'h0ABCDE; wr_ptr = 22'h123456;
    rd_req = 1; wr_req = 1;
    step();
    wr_req = 0;
    chk("R3 write wins after reset", wr_ack, 1);
    chk("R3 read not granted", rd_ack, 0);
    step();
    chk("R8 write ptr", start_ptr, 22'h123456);
    release_side(1);
    chk("R7 no grant on release edge", rd_ack, 0);
    wr_req = 1;
    step();
    rd_req = 0; wr_req = 1;
    chk("R4 read wins after write grant", rd_ack, 1);
    chk("R4 write waits", wr_ack, 0);
    step();
    chk("R8 read ptr and dir", {start_is_wr, start_ptr}, {1'b0, 22'h0ABCDE});
    rd_req = 1;
    release_side(0);
    step();
    rd_req = 0; wr_req = 0;
    chk("R4 write wins after read grant", wr_ack, 1);
    chk("R4 read waits", rd_ack, 0);
    step();
    release_side(1);
  endtask

  task automatic t_r5_r6_busy();
    do_reset();
    wr_ptr = 22'h3FFFFF;
    wr_req = 1;
    step();
    wr_req = 0;
    rd_req = 1;
    for (int i = 0; i < 5; i++) begin
      rd_ptr = 22'h000100 + 22'(i);
      wr_ptr = 22'h000200 + 22'(i);
      step();
      chk("R5 no ack while busy", {rd_ack, wr_ack}, 0);
      chk("R8 ptr held while busy", start_ptr, 22'h3FFFFF);
    end
    rd_done = 1;
    step();
    rd_done = 0;
    chk("R6 wrong done ignored", busy, 1);
    rd_req = 0;
    step();
    chk("R5 still no ack", {rd_ack, wr_ack}, 0);
    release_side(1);
    wr_done = 1; rd_done = 1;
    step();
    wr_done = 0; rd_done = 0;
    step();
    chk("R6 done while idle ignored", {busy, rd_ack, wr_ack, start}, 0);
  endtask

  initial begin
    t_r1_reset();
    t_r2_single(1, 22'h000001);
    t_r2_single(0, 22'h2AAAAA);
    t_r3_r4_alternate();
    t_r5_r6_busy();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule